// File: doc/BRIEF.md
# Flash read response multiplexer

This block forms the read side of a parallel NOR flash device model driven by a command sequencer elsewhere. Every bus read strobe picks one response from the command state the sequencer holds. The response is one of four sources: array data, a manufacturer or device identifier word, the status byte, or a byte from an external query table. A status read also hands the sequencer an updated status byte in which one bit has flipped, so software polling the device sees that bit alternate. An unknown command state asks the sequencer to go back to idle.

The caller presents the low byte of the byte address. The caller also presents the four array bytes that start at that address and the status byte. The query table is an external constant source: the block drives the table index and takes back one byte in the same cycle. The response is registered by default and appears one cycle after the strobe. A parameter selects a combinational variant instead.

Top module: `flash_rdmux`

## Requirements
- R1: The lookup offset is the address byte shifted right by 0, 1 or 2 places. The shift depends on `bus_width`: 0 is a 1-byte bus, 1 is a 2-byte bus, 2 is a 4-byte bus, and the reserved code 3 behaves as 1-byte.
- R2: In idle (code 0) and erase-setup (code 1) states, a read returns array data assembled little-endian. Bits 7:0 of `array_word` are the byte at the lowest address. Only 1, 2 or 4 low lanes are kept, following the bus width, and the remaining lanes read 0.
- R3: In the identifier state (code 2), offset 0 returns `id_word0` and offset 1 returns `id_word1`, both zero-extended. Offset 2 returns 0, meaning no sector is protected.
- R4: In the identifier state, offsets 0x0E and 0x0F return `id_word2` and `id_word3`. If the selected word equals 0x00FF, array data is returned instead. Every other offset returns array data.
- R5: In the program (3), chip-erase (4) and sector-erase (5) states, a read returns `status_in`. In the same cycle as the strobe, `status_we` pulses with `status_next` equal to `status_in` with bit 6 inverted. This happens once for each strobe cycle.
- R6: In the query state (6), `cfi_idx` carries the offset. An offset of 0x52 or below returns `cfi_byte`, and an offset above 0x52 returns 0.
- R7: For the undefined state code 7, a strobe pulses `force_idle` in the same cycle and returns array data.
- R8: With the registered variant, `rd_data` and `rd_valid` update one cycle after a strobe. Without a strobe, `rd_valid` is 0 and `rd_data` holds. Reset clears both to 0.
- R9: Without a strobe, `status_we` and `force_idle` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Read strobe, one read per cycle high |
| cmd_state | input | 3 | Command state code from the sequencer |
| byte_addr | input | 8 | Low byte of the read byte address |
| bus_width | input | 2 | Bus width code (0:1B, 1:2B, 2:4B, 3:1B) |
| id_word0 | input | 16 | Identifier word 0 |
| id_word1 | input | 16 | Identifier word 1 |
| id_word2 | input | 16 | Identifier word 2 (0x00FF means absent) |
| id_word3 | input | 16 | Identifier word 3 (0x00FF means absent) |
| array_word | input | 32 | Four array bytes starting at the address, lowest in bits 7:0 |
| status_in | input | 8 | Current status byte |
| cfi_byte | input | 8 | Query table byte at `cfi_idx` |
| cfi_idx | output | 8 | Query table index |
| rd_data | output | 32 | Read response |
| rd_valid | output | 1 | Response valid |
| status_we | output | 1 | Status update strobe |
| status_next | output | 8 | Updated status byte |
| force_idle | output | 1 | Request to return the sequencer to idle |

## Verification
The hardest case to reach from the ports is a run of back-to-back status reads. Each strobe cycle must flip bit 6 exactly once, and each strobe must return the value left by the read before it. The bench closes that loop with a small sequencer model that writes `status_next` back into `status_in`. It holds the strobe high across consecutive cycles and checks the alternating sequence. It also loads an identifier word with 0x00FF to force the fallback to array data, and it reads the query table on both sides of its last index.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
   typedef enum logic [2:0] {
      RS_IDLE    = 3'd0,
      RS_ESETUP  = 3'd1,
      RS_AUTOSEL = 3'd2,
      RS_PROG    = 3'd3,
      RS_CHIPER  = 3'd4,
      RS_SECTER  = 3'd5,
      RS_QUERY   = 3'd6,
      RS_BAD     = 3'd7
   } rd_state_e;

   typedef enum logic [1:0] {
      BW_1   = 2'd0,
      BW_2   = 2'd1,
      BW_4   = 2'd2,
      BW_RSV = 2'd3
   } bus_w_e;

   localparam int OFF_W = 8;
endpackage

// File: rtl/flash_rd_offset.sv
module flash_rd_offset
   import flash_rd_pkg::*;
(
   input  logic [OFF_W-1:0] byte_addr,
   input  logic [1:0]       bus_width,
   output logic [OFF_W-1:0] reg_off
);
   always_comb begin
      unique case (bus_w_e'(bus_width))
         BW_2:    reg_off = {1'b0, byte_addr[OFF_W-1:1]};
         BW_4:    reg_off = {2'b00, byte_addr[OFF_W-1:2]};
         default: reg_off = byte_addr;
      endcase
   end
endmodule

// File: rtl/flash_rd_lanes.sv
module flash_rd_lanes
   import flash_rd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANE_N = 4
) (
   input  logic [BYTE_W*LANE_N-1:0] array_word,
   input  logic [1:0]               bus_width,
   output logic [BYTE_W*LANE_N-1:0] arr_data
);
   logic [2:0] n_live;

   always_comb begin
      unique case (bus_w_e'(bus_width))
         BW_2:    n_live = 3'd2;
         BW_4:    n_live = 3'd4;
         default: n_live = 3'd1;
      endcase
   end

   for (genvar k = 0; k < LANE_N; k++) begin : g_lane
      assign arr_data[k*BYTE_W +: BYTE_W] =
         (k < int'(n_live)) ? array_word[k*BYTE_W +: BYTE_W] : '0;
   end
endmodule

// File: rtl/flash_rd_idsel.sv
module flash_rd_idsel
   import flash_rd_pkg::*;
#(
   parameter int ID_W = 16
) (
   input  logic [OFF_W-1:0] reg_off,
   input  logic [ID_W-1:0]  id0,
   input  logic [ID_W-1:0]  id1,
   input  logic [ID_W-1:0]  id2,
   input  logic [ID_W-1:0]  id3,
   output logic             id_hit,
   output logic [ID_W-1:0]  id_val
);
   localparam logic [ID_W-1:0] ABSENT = ID_W'(8'hFF);

   always_comb begin
      id_hit = 1'b0;
      id_val = '0;
      unique case (reg_off)
         8'h00: begin id_hit = 1'b1; id_val = id0; end
         8'h01: begin id_hit = 1'b1; id_val = id1; end
         8'h02: begin id_hit = 1'b1; id_val = '0;  end
         8'h0E: begin id_hit = (id2 != ABSENT); id_val = id2; end
         8'h0F: begin id_hit = (id3 != ABSENT); id_val = id3; end
         default: ;
      endcase
   end
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
   import flash_rd_pkg::*;
#(
   parameter int           BYTE_W   = 8,
   parameter int           LANE_N   = 4,
   parameter int           ID_W     = 16,
   parameter logic [7:0]   CFI_LAST = 8'h52,
   parameter logic [7:0]   TOG_MASK = 8'h40,
   parameter bit           REG_OUT  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_stb,
   input  logic [2:0]               cmd_state,
   input  logic [7:0]               byte_addr,
   input  logic [1:0]               bus_width,
   input  logic [ID_W-1:0]          id_word0,
   input  logic [ID_W-1:0]          id_word1,
   input  logic [ID_W-1:0]          id_word2,
   input  logic [ID_W-1:0]          id_word3,
   input  logic [BYTE_W*LANE_N-1:0] array_word,
   input  logic [7:0]               status_in,
   input  logic [7:0]               cfi_byte,
   output logic [7:0]               cfi_idx,
   output logic [BYTE_W*LANE_N-1:0] rd_data,
   output logic                     rd_valid,
   output logic                     status_we,
   output logic [7:0]               status_next,
   output logic                     force_idle
);
   localparam int DATA_W = BYTE_W * LANE_N;

   initial begin
      assert (BYTE_W == 8) else $error("byte lanes must be 8 bits");
      assert (LANE_N >= 4) else $error("at least four lanes required");
      assert (DATA_W >= ID_W) else $error("data narrower than id word");
   end

   rd_state_e         st;
   logic [OFF_W-1:0]  reg_off;
   logic [DATA_W-1:0] arr_data;
   logic              id_hit;
   logic [ID_W-1:0]   id_val;
   logic [DATA_W-1:0] rsp;
   logic              is_stat;

   assign st = rd_state_e'(cmd_state);

   flash_rd_offset u_off (
      .byte_addr (byte_addr),
      .bus_width (bus_width),
      .reg_off   (reg_off)
   );

   flash_rd_lanes #(.BYTE_W(BYTE_W), .LANE_N(LANE_N)) u_lanes (
      .array_word (array_word),
      .bus_width  (bus_width),
      .arr_data   (arr_data)
   );

   flash_rd_idsel #(.ID_W(ID_W)) u_id (
      .reg_off (reg_off),
      .id0     (id_word0),
      .id1     (id_word1),
      .id2     (id_word2),
      .id3     (id_word3),
      .id_hit  (id_hit),
      .id_val  (id_val)
   );

   assign cfi_idx = reg_off;
   assign is_stat = (st == RS_PROG) || (st == RS_CHIPER) || (st == RS_SECTER);

   always_comb begin
      unique case (st)
         RS_AUTOSEL: rsp = id_hit ? DATA_W'(id_val) : arr_data;
         RS_PROG,
         RS_CHIPER,
         RS_SECTER:  rsp = DATA_W'(status_in);
         RS_QUERY:   rsp = (reg_off > CFI_LAST) ? '0 : DATA_W'(cfi_byte);
         default:    rsp = arr_data;
      endcase
   end

   assign status_we   = rd_stb & is_stat;
   assign status_next = status_in ^ TOG_MASK;
   assign force_idle  = rd_stb & (st == RS_BAD);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
         end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= rsp;
         end
      end

      // R5: a status read returns the byte seen at the strobe
      a_r5_status_ret: assert property (@(posedge clk) disable iff (!rst_n)
         status_we |=> rd_data == DATA_W'($past(status_in)));
      // R6: offsets past the table end read zero
      a_r6_cfi_beyond: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && cmd_state == 3'd6 && cfi_idx > CFI_LAST) |=> rd_data == '0);
      // R3: protection word reads zero
      a_r3_noprot: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && cmd_state == 3'd2 && cfi_idx == 8'h02) |=> rd_data == '0);
      // R8: no strobe, output holds and is not valid
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_stb |=> ($stable(rd_data) && !rd_valid));
      // R7: undefined state returns array data
      a_r7_bad_arr: assert property (@(posedge clk) disable iff (!rst_n)
         force_idle |=> rd_data == $past(arr_data));
   end else begin : g_comb
      assign rd_data  = rsp;
      assign rd_valid = rd_stb;
   end
endmodule

// File: tb/sim_flash_rdmux.sv
`timescale 1ns/1ps
module sim_flash_rdmux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_stb = 1'b0;
   logic [2:0]  cmd_state = 3'd0;
   logic [7:0]  byte_addr = 8'h00;
   logic [1:0]  bus_width = 2'd0;
   logic [15:0] id_word0 = 16'h0001;
   logic [15:0] id_word1 = 16'h227E;
   logic [15:0] id_word2 = 16'h2210;
   logic [15:0] id_word3 = 16'h2201;
   logic [31:0] array_word;
   logic [7:0]  status_in;
   logic [7:0]  cfi_byte;
   logic [7:0]  cfi_idx;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        status_we;
   logic [7:0]  status_next;
   logic        force_idle;

   logic [7:0]  stat_reg = 8'h80;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   // array bytes equal their own address; query table is index xor A5
   assign array_word = {byte_addr + 8'd3, byte_addr + 8'd2, byte_addr + 8'd1, byte_addr};
   assign cfi_byte   = cfi_idx ^ 8'hA5;
   assign status_in  = stat_reg;

   // sequencer model: take the status update back
   always @(posedge clk) if (status_we) stat_reg <= status_next;

   flash_rdmux u0 (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .cmd_state(cmd_state),
      .byte_addr(byte_addr), .bus_width(bus_width),
      .id_word0(id_word0), .id_word1(id_word1), .id_word2(id_word2), .id_word3(id_word3),
      .array_word(array_word), .status_in(status_in), .cfi_byte(cfi_byte),
      .cfi_idx(cfi_idx), .rd_data(rd_data), .rd_valid(rd_valid),
      .status_we(status_we), .status_next(status_next), .force_idle(force_idle)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] st, input logic [7:0] a, input logic [1:0] w,
                     input logic [31:0] exp, input string tag);
      @(negedge clk);
      cmd_state = st; byte_addr = a; bus_width = w; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      chk(tag, rd_data, exp);
      chk({tag, " valid"}, {31'd0, rd_valid}, 32'd1);
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // fields: state(3) addr(8) width(2) expected(32)
   localparam int NV = 16;
   localparam logic [44:0] VEC [NV] = '{
      {3'd0, 8'h40, 2'd0, 32'h0000_0040},   // R2 idle byte
      {3'd0, 8'h40, 2'd1, 32'h0000_4140},   // R2 idle half
      {3'd0, 8'h40, 2'd2, 32'h4342_4140},   // R2 idle word
      {3'd1, 8'h10, 2'd2, 32'h1312_1110},   // R2 erase setup
      {3'd2, 8'h00, 2'd1, 32'h0000_0001},   // R3 id0
      {3'd2, 8'h02, 2'd1, 32'h0000_227E},   // R1 R3 id1 on 2-byte bus
      {3'd2, 8'h08, 2'd2, 32'h0000_0000},   // R1 R3 protection on 4-byte bus
      {3'd2, 8'h0E, 2'd0, 32'h0000_2210},   // R4 id2
      {3'd2, 8'h3C, 2'd2, 32'h0000_2201},   // R1 R4 id3
      {3'd2, 8'h05, 2'd0, 32'h0000_0005},   // R4 other offset -> array
      {3'd6, 8'h20, 2'd1, 32'h0000_00B5},   // R6 table byte 0x10
      {3'd6, 8'h52, 2'd0, 32'h0000_00F7},   // R6 last index
      {3'd6, 8'h53, 2'd0, 32'h0000_0000},   // R6 past end
      {3'd6, 8'hFF, 2'd1, 32'h0000_0000},   // R1 R6 0x7F past end
      {3'd6, 8'h30, 2'd3, 32'h0000_0095},   // R1 reserved width as 1-byte
      {3'd0, 8'h34, 2'd3, 32'h0000_0034}    // R2 reserved width lanes
   };

   initial begin
      #(200000 * 5);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   initial begin
      #12;
      chk("R8 reset data", rd_data, 32'd0);
      chk("R8 reset valid", {31'd0, rd_valid}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         rd(VEC[i][44:42], VEC[i][41:34], VEC[i][33:32], VEC[i][31:0],
            $sformatf("vec%0d", i));
      end

      // R4 absent word falls back to array
      id_word2 = 16'h00FF;
      rd(3'd2, 8'h0E, 2'd0, 32'h0000_000E, "R4 absent id2");

      // R9 idle read: no status update, no idle request
      @(negedge clk);
      cmd_state = 3'd0; byte_addr = 8'h20; bus_width = 2'd0; rd_stb = 1'b1;
      #1;
      chk("R9 idle status_we", {31'd0, status_we}, 32'd0);
      chk("R9 idle force_idle", {31'd0, force_idle}, 32'd0);
      @(negedge clk); rd_stb = 1'b0;

      // R5 single status read in program state
      @(negedge clk);
      cmd_state = 3'd3; rd_stb = 1'b1;
      #1;
      chk("R5 status_we", {31'd0, status_we}, 32'd1);
      chk("R5 status_next", {24'd0, status_next}, 32'h0000_00C0);
      @(negedge clk); rd_stb = 1'b0;
      chk("R5 prog status", rd_data, 32'h0000_0080);
      chk("R5 toggled once", {24'd0, stat_reg}, 32'h0000_00C0);
      #1;
      chk("R9 no strobe status_we", {31'd0, status_we}, 32'd0);

      // R8 hold without strobe
      @(negedge clk);
      chk("R8 hold data", rd_data, 32'h0000_0080);
      chk("R8 hold valid", {31'd0, rd_valid}, 32'd0);

      // R5 back-to-back strobes, chip erase then sector erase
      @(negedge clk);
      cmd_state = 3'd4; rd_stb = 1'b1;
      @(negedge clk);
      chk("R5 chip erase 1st", rd_data, 32'h0000_00C0);
      cmd_state = 3'd5;
      @(negedge clk);
      chk("R5 sector erase 2nd", rd_data, 32'h0000_0080);
      @(negedge clk);
      rd_stb = 1'b0;
      chk("R5 3rd consecutive", rd_data, 32'h0000_00C0);
      chk("R5 three toggles", {24'd0, stat_reg}, 32'h0000_0080);

      // R7 undefined state
      @(negedge clk);
      cmd_state = 3'd7; byte_addr = 8'h21; bus_width = 2'd1; rd_stb = 1'b1;
      #1;
      chk("R7 force_idle", {31'd0, force_idle}, 32'd1);
      chk("R7 no status_we", {31'd0, status_we}, 32'd0);
      @(negedge clk); rd_stb = 1'b0;
      chk("R7 array data", rd_data, 32'h0000_2221);
      #1;
      chk("R9 force_idle low", {31'd0, force_idle}, 32'd0);

      report();
   end
endmodule